// File: doc/BRIEF.md
# Threshold-Managed Transmit Packet FIFO

This block is a byte-wide packet queue placed between a packet source and a transmit engine. The source pushes bytes tagged with start and end markers and is held off by a ready signal. The engine pulls bytes one at a time with a request line. Each pulled byte appears on the output one cycle after the pull.

Four run-time thresholds control the queue. The start threshold sets the fill level at which a packet may begin to leave; a value of zero selects store-and-forward, where a packet waits until its end marker has been stored. The warn threshold raises an early warning to the source when free space runs low. The almost-full threshold drops ready before the storage can overflow. The almost-empty threshold cuts short a packet that would otherwise run dry before its end marker arrives. An aborted packet is signalled with an error pulse. Its remaining bytes are discarded up to and including its end marker, and the next packet then goes out normally.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After reset, wr_ready is 1 and rd_valid, rd_err, wr_warn and wr_afull are 0.
- R2: With a non-zero start threshold, a packet may begin to leave once the stored level reaches that threshold, before its end marker is stored. Each request accepted in cycle t yields rd_valid with the next byte in cycle t+1, and bytes leave in write order.
- R3: With a start threshold of 0, no byte of a packet leaves until its end marker has been stored.
- R4: wr_warn is 1 exactly when the free space (depth minus level) is at or below the warn threshold.
- R5: wr_afull is 1 and wr_ready is 0 exactly when the free space is at or below the almost-full threshold.
- R6: A write presented while wr_ready is 0 is ignored. No byte is lost or duplicated, and the level never exceeds the depth.
- R7: While a packet is leaving and no end marker is stored, reaching a level at or below the almost-empty threshold ends the packet. The block then gives a one-cycle rd_err pulse with rd_valid at 0, so exactly the stored length minus the threshold has been delivered.
- R8: After an abort, the remaining bytes of that packet, through its end marker, are discarded without rd_valid. The following packet leaves intact.
- R9: rd_sop marks the first byte of each delivered packet, and rd_eop marks its last byte.
- R10: Threshold writes use cfg_sel codes 0 = start, 1 = warn, 2 = almost-full and 3 = almost-empty. A new value affects the flags from the second cycle after the write.
- R11: An end marker written in the same cycle in which the level would otherwise fall to the almost-empty threshold prevents the abort, and the whole packet is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select (0 start, 1 warn, 2 almost-full, 3 almost-empty) |
| cfg_wdata | input | AW+1 | Threshold value in bytes |
| wr_valid | input | 1 | Source byte present |
| wr_data | input | 8 | Source byte |
| wr_sop | input | 1 | First byte of a packet |
| wr_eop | input | 1 | Last byte of a packet |
| wr_ready | output | 1 | Queue accepts a byte this cycle |
| wr_warn | output | 1 | Free space at or below warn threshold |
| wr_afull | output | 1 | Free space at or below almost-full threshold |
| rd_req | input | 1 | Engine pulls one byte |
| rd_valid | output | 1 | Output byte valid |
| rd_data | output | 8 | Output byte |
| rd_sop | output | 1 | Output byte starts a packet |
| rd_eop | output | 1 | Output byte ends a packet |
| rd_err | output | 1 | Packet in flight aborted |

## Verification
The sharpest overlap is a write and a pull in the same cycle, in particular an end-marker write that lands exactly when a pull would bring the level down to the almost-empty threshold. The bench prefills a partial packet, starts pulling, and times the end-marker write to that cycle. The full packet must arrive with no error pulse. An abort run without that write gives the contrasting outcome, and steady cut-through runs keep pushes and pulls overlapping for whole packets.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  typedef enum logic [1:0] {RS_IDLE, RS_SEND, RS_DRAIN} rstate_t;

  typedef struct packed {
    logic sop;
    logic eop;
  } mark_t;

  localparam logic [1:0] SEL_START  = 2'd0;
  localparam logic [1:0] SEL_WARN   = 2'd1;
  localparam logic [1:0] SEL_AFULL  = 2'd2;
  localparam logic [1:0] SEL_AEMPTY = 2'd3;
endpackage

// File: rtl/tpf_regs.sv
module tpf_regs #(
  parameter int TW = 7,
  parameter int RST_START  = 16,
  parameter int RST_WARN   = 48,
  parameter int RST_AFULL  = 3,
  parameter int RST_AEMPTY = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] thr_start,
  output logic [TW-1:0] thr_warn,
  output logic [TW-1:0] thr_afull,
  output logic [TW-1:0] thr_aempty
);
  localparam int NREG = 4;
  localparam logic [TW-1:0] RV [NREG] = '{TW'(RST_START), TW'(RST_WARN),
                                          TW'(RST_AFULL), TW'(RST_AEMPTY)};
  logic [TW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RV[i];
      else if (cfg_we && cfg_sel == 2'(i))
        regs[i] <= cfg_wdata;
    end
  end

  assign thr_start  = regs[0];
  assign thr_warn   = regs[1];
  assign thr_afull  = regs[2];
  assign thr_aempty = regs[3];
endmodule

// File: rtl/tpf_store.sv
module tpf_store
  import tpf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  mark_t         wmark,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output mark_t         rmark
);
  localparam int DEPTH = 1 << AW;

  // Byte payload: synchronous read so that block RAM can be used.
  logic [7:0] mem [DEPTH];
  // Packet markers: narrow array read asynchronously by the read control.
  mark_t      marks [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) marks[waddr] <= wmark;
  end

  assign rmark = marks[raddr];
endmodule

// File: rtl/tpf_level.sv
module tpf_level #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          push_eop,
  input  logic          pop_eop,
  input  logic [AW:0]   thr_start,
  input  logic [AW:0]   thr_warn,
  input  logic [AW:0]   thr_afull,
  input  logic [AW:0]   thr_aempty,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   lvl,
  output logic          nonempty,
  output logic          warn_q,
  output logic          afull_q,
  output logic          aempty_q,
  output logic          start_q
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [AW:0] wptr, rptr, eop_cnt;
  logic [AW:0] wptr_n, rptr_n, eop_n, lvl_n, free_n;

  always_comb begin
    wptr_n = wptr + (AW+1)'(push);
    rptr_n = rptr + (AW+1)'(pop);
    lvl_n  = wptr_n - rptr_n;
    free_n = FULLV - lvl_n;
    eop_n  = eop_cnt;
    if (push_eop && !pop_eop)
      eop_n = eop_cnt + (AW+1)'(1);
    else if (!push_eop && pop_eop)
      eop_n = eop_cnt - (AW+1)'(1);
  end

  // Flags are registered from next-state values so they agree with the pointers.
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      eop_cnt  <= '0;
      warn_q   <= 1'b0;
      afull_q  <= 1'b0;
      aempty_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      wptr     <= wptr_n;
      rptr     <= rptr_n;
      eop_cnt  <= eop_n;
      warn_q   <= free_n <= thr_warn;
      afull_q  <= free_n <= thr_afull;
      aempty_q <= (lvl_n <= thr_aempty) && (eop_n == '0);
      start_q  <= (eop_n != '0) || ((thr_start != '0) && (lvl_n >= thr_start));
    end
  end

  assign waddr    = wptr[AW-1:0];
  assign raddr    = rptr[AW-1:0];
  assign lvl      = wptr - rptr;
  assign nonempty = wptr != rptr;
endmodule

// File: rtl/tpf_rdctl.sv
module tpf_rdctl
  import tpf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_req,
  input  logic  nonempty,
  input  logic  aempty_q,
  input  logic  start_q,
  input  mark_t tail,
  output logic  pop,
  output logic  pop_eop,
  output logic  rd_valid,
  output logic  rd_sop,
  output logic  rd_eop,
  output logic  rd_err
);
  rstate_t st;
  logic    send_pop;

  always_comb begin
    send_pop = (st == RS_SEND) && rd_req && !aempty_q && nonempty;
    pop      = send_pop || ((st == RS_DRAIN) && nonempty);
    pop_eop  = pop && tail.eop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RS_IDLE;
      rd_valid <= 1'b0;
      rd_sop   <= 1'b0;
      rd_eop   <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= send_pop;
      rd_sop   <= send_pop && tail.sop;
      rd_eop   <= send_pop && tail.eop;
      rd_err   <= (st == RS_SEND) && aempty_q;
      unique case (st)
        RS_IDLE:  if (start_q) st <= RS_SEND;
        RS_SEND:  if (aempty_q) st <= RS_DRAIN;
                  else if (pop_eop) st <= RS_IDLE;
        RS_DRAIN: if (pop_eop) st <= RS_IDLE;
        default:  st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo
  import tpf_pkg::*;
#(
  parameter int AW = 6,
  parameter int RST_START  = 16,
  parameter int RST_WARN   = (1 << AW) - 16,
  parameter int RST_AFULL  = 3,
  parameter int RST_AEMPTY = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [AW:0] cfg_wdata,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_sop,
  input  logic        wr_eop,
  output logic        wr_ready,
  output logic        wr_warn,
  output logic        wr_afull,
  input  logic        rd_req,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_sop,
  output logic        rd_eop,
  output logic        rd_err
);
  localparam int TW = AW + 1;

  logic [TW-1:0] thr_start, thr_warn, thr_afull, thr_aempty;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   lvl;
  logic          nonempty, aempty_q, start_q, afull_q;
  logic          push, pop, pop_eop;
  mark_t         wmark, tail;

  assign wr_ready = !afull_q;
  assign wr_afull = afull_q;
  assign push     = wr_valid && !afull_q;
  assign wmark    = '{sop: wr_sop, eop: wr_eop};

  tpf_regs #(
    .TW(TW), .RST_START(RST_START), .RST_WARN(RST_WARN),
    .RST_AFULL(RST_AFULL), .RST_AEMPTY(RST_AEMPTY)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .thr_start(thr_start), .thr_warn(thr_warn), .thr_afull(thr_afull),
    .thr_aempty(thr_aempty)
  );

  tpf_level #(.AW(AW)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_eop(push && wr_eop), .pop_eop(pop_eop),
    .thr_start(thr_start), .thr_warn(thr_warn), .thr_afull(thr_afull),
    .thr_aempty(thr_aempty), .waddr(waddr), .raddr(raddr), .lvl(lvl),
    .nonempty(nonempty), .warn_q(wr_warn), .afull_q(afull_q),
    .aempty_q(aempty_q), .start_q(start_q)
  );

  tpf_store #(.AW(AW)) u_store (
    .clk(clk), .we(push), .waddr(waddr), .wdata(wr_data), .wmark(wmark),
    .re(pop), .raddr(raddr), .rdata(rd_data), .rmark(tail)
  );

  tpf_rdctl u_rdctl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .nonempty(nonempty),
    .aempty_q(aempty_q), .start_q(start_q), .tail(tail),
    .pop(pop), .pop_eop(pop_eop), .rd_valid(rd_valid), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_err(rd_err)
  );
endmodule

// File: rtl/tx_pkt_fifo_chk.sv
module tx_pkt_fifo_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        rd_err,
  input logic        wr_warn,
  input logic        wr_afull,
  input logic        wr_ready,
  input logic [AW:0] lvl,
  input logic [AW:0] thr_warn,
  input logic [AW:0] thr_afull
);
  localparam logic [AW:0] FULLV = (AW+1)'(1 << AW);

  // R2: output byte only after a pull in the previous cycle
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  // R4: warning tracks free space
  a_r4_warn_level: assert property (@(posedge clk) disable iff (rst)
    $stable(thr_warn) |-> (wr_warn == ((FULLV - lvl) <= thr_warn)));

  // R5: almost-full tracks free space and blocks the source
  a_r5_afull_level: assert property (@(posedge clk) disable iff (rst)
    $stable(thr_afull) |-> (wr_afull == ((FULLV - lvl) <= thr_afull)));

  // R6: level never exceeds the storage
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    lvl <= FULLV);

  // R7: abort is a single pulse
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> !rd_err);

  // R7: abort carries no data
  a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !rd_valid);
endmodule

bind tx_pkt_fifo tx_pkt_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid), .rd_err(rd_err),
  .wr_warn(wr_warn), .wr_afull(wr_afull), .wr_ready(wr_ready), .lvl(lvl),
  .thr_warn(thr_warn), .thr_afull(thr_afull)
);

// File: tb/sim_tx_pkt_fifo.sv
module sim_tx_pkt_fifo;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW:0] cfg_wdata = '0;
  logic wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic wr_ready, wr_warn, wr_afull, rd_valid, rd_sop, rd_eop, rd_err;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  tx_pkt_fifo #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_ready(wr_ready), .wr_warn(wr_warn), .wr_afull(wr_afull),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_err(rd_err)
  );

  int n_chk = 0, n_bad = 0;
  int cap_n = 0, err_n = 0, errv_n = 0, errpair_n = 0;
  logic [7:0] cap_d [256];
  bit cap_s [256], cap_e [256];
  bit prev_err = 1'b0;
  time t_first = 0, t_eopw = 0;

  // {start threshold, almost-empty threshold, length, first byte}
  localparam int TBL [4][4] = '{
    '{0, 8, 5, 8'h20},
    '{0, 8, 1, 8'h33},
    '{16, 8, 40, 8'h10},
    '{10, 2, 30, 8'h80}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (cap_n == 0) t_first = $time;
        if (cap_n < 256) begin
          cap_d[cap_n] = rd_data; cap_s[cap_n] = rd_sop; cap_e[cap_n] = rd_eop;
        end
        cap_n++;
      end
      if (rd_err) begin
        err_n++;
        if (rd_valid) errv_n++;
        if (prev_err) errpair_n++;
      end
      prev_err = rd_err;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    cap_n = 0; err_n = 0; errv_n = 0; errpair_n = 0;
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = (AW+1)'(val);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_byte(input int d, input bit s, input bit e);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'(d); wr_sop = s; wr_eop = e;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    if (e) t_eopw = $time;
  endtask

  task automatic wr_pkt(input int base, input int len, input bit with_eop);
    for (int i = 0; i < len; i++) wr_byte(base + i, i == 0, with_eop && i == len - 1);
    @(negedge clk); wr_valid = 1'b0; wr_eop = 1'b0; wr_sop = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_err", int'(rd_err), 0);
    chk("R1 wr_warn", int'(wr_warn), 0);
    chk("R1 wr_afull", int'(wr_afull), 0);

    // R10 warn threshold reprogrammed on an empty queue (free = 64)
    cfg(2'd1, 64);
    @(negedge clk);
    chk("R10 warn after cfg 64", int'(wr_warn), 1);
    cfg(2'd1, 48);
    @(negedge clk);
    chk("R10 warn after cfg 48", int'(wr_warn), 0);

    // R2 R3 R9 table of packets, pulls enabled while writing
    for (int v = 0; v < 4; v++) begin
      cfg(2'd0, TBL[v][0]);
      cfg(2'd3, TBL[v][1]);
      clr();
      rd_req = 1'b1;
      wr_pkt(TBL[v][3], TBL[v][2], 1'b1);
      repeat (TBL[v][2] + 30) @(negedge clk);
      chk("R2 byte count", cap_n, TBL[v][2]);
      chk("R7 no abort", err_n, 0);
      for (int i = 0; i < TBL[v][2]; i++)
        chk("R2 byte order", int'(cap_d[i]), (TBL[v][3] + i) & 255);
      chk("R9 sop first", int'(cap_s[0]), 1);
      chk("R9 eop last", int'(cap_e[TBL[v][2] - 1]), 1);
      if (TBL[v][0] == 0)
        chk("R3 waits for eop", int'(t_first > t_eopw), 1);
      else
        chk("R2 starts before eop", int'(t_first < t_eopw), 1);
    end
    rd_req = 1'b0;

    // R4 R5 R6 flags while filling in store-and-forward mode
    cfg(2'd0, 0);
    clr();
    for (int k = 1; k <= 61; k++) begin
      wr_byte(k - 1, k == 1, k == 61);
      #1;
      if (k == 15) chk("R4 warn at free 49", int'(wr_warn), 0);
      if (k == 16) chk("R4 warn at free 48", int'(wr_warn), 1);
      if (k == 60) begin
        chk("R5 afull at free 4", int'(wr_afull), 0);
        chk("R5 ready at free 4", int'(wr_ready), 1);
      end
      if (k == 61) begin
        chk("R5 afull at free 3", int'(wr_afull), 1);
        chk("R5 ready at free 3", int'(wr_ready), 0);
      end
    end
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hEE; wr_sop = 1'b1; wr_eop = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6 ready stays low", int'(wr_ready), 0);
    end
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    rd_req = 1'b1;
    repeat (90) @(negedge clk);
    chk("R6 no byte lost or duplicated", cap_n, 61);
    for (int i = 0; i < 61; i++) chk("R6 byte value", int'(cap_d[i]), i);
    chk("R9 eop on byte 61", int'(cap_e[60]), 1);
    chk("R4 warn clear when empty", int'(wr_warn), 0);
    chk("R5 afull clear when empty", int'(wr_afull), 0);
    rd_req = 1'b0;

    // R7 R8 abort of a packet that runs dry, then drain and recovery
    cfg(2'd0, 16);
    cfg(2'd3, 8);
    clr();
    wr_pkt(8'h40, 20, 1'b0);
    repeat (3) @(negedge clk);
    rd_req = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 bytes before abort", cap_n, 12);
    chk("R7 one abort pulse", err_n, 1);
    chk("R7 abort without data", errv_n, 0);
    chk("R7 pulse width one", errpair_n, 0);
    for (int i = 0; i < 12; i++) begin
      chk("R7 byte value", int'(cap_d[i]), 8'h40 + i);
      chk("R7 no eop before abort", int'(cap_e[i]), 0);
    end
    wr_pkt(8'h60, 5, 1'b1);
    wr_pkt(8'h90, 6, 1'b1);
    repeat (30) @(negedge clk);
    chk("R8 discarded tail not delivered", cap_n, 18);
    chk("R8 no second abort", err_n, 1);
    for (int i = 0; i < 6; i++) chk("R8 next packet byte", int'(cap_d[12 + i]), 8'h90 + i);
    chk("R9 sop on next packet", int'(cap_s[12]), 1);
    chk("R9 eop on next packet", int'(cap_e[17]), 1);
    rd_req = 1'b0;

    // R11 end marker written in the cycle the level would reach almost-empty
    clr();
    wr_pkt(8'hA0, 16, 1'b0);
    repeat (3) @(negedge clk);
    rd_req = 1'b1;
    repeat (7) @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hB0; wr_sop = 1'b0; wr_eop = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_eop = 1'b0;
    repeat (30) @(negedge clk);
    chk("R11 full packet delivered", cap_n, 17);
    chk("R11 no abort", err_n, 0);
    chk("R11 last byte", int'(cap_d[16]), 8'hB0);
    chk("R11 last byte eop", int'(cap_e[16]), 1);
    rd_req = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule